// File: doc/BRIEF.md
# Row-Colored Character Overlay Generator

This block draws a text overlay on a video raster. Horizontal and vertical sync come in on the block's clock, which stands for the local dot oscillator. The block holds a screen of 8 text rows by 20 character columns, a glyph store of 128 characters, and a color per text row. From these it produces red, green, blue and blank dot outputs. Each character cell is 11 dots wide and 15 lines tall. The overlay window is therefore 220 dots by 120 lines. Its top-left corner sits at a programmable dot offset after horizontal sync and a programmable line offset after vertical sync.

Color is chosen per text row. One row can be switched to a level-bar mode. In that mode, columns at and beyond a programmable split column take a second color, which suits volume-style indicators. The block also produces a dot-enable output that models gating of the dot oscillator. Dots stop shortly after the leading edge of horizontal sync and restart a fixed time after its trailing edge, so every line starts on the same dot phase.

All contents are loaded through a host write port that uses a valid/ready handshake. The port never applies back-pressure once reset is released: `wr_ready` is held high. A write is taken on every rising edge where both `wr_valid` and `wr_ready` are high, and the port accepts one write per clock.

Top module: `row_osd`

## Requirements
- R1: `dot_en` goes low at the second rising clock edge at which `hsync` is sampled high, and stays low while `hsync` stays high. After `hsync` is first sampled low, `dot_en` stays low through that edge and returns high at the next edge.
- R2: A dot is inside the window when its dot count h (enabled cycles since `dot_en` rose, starting at 0) satisfies hstart <= h < hstart+220 and its line count v satisfies vstart <= v < vstart+120. For every dot outside the window, `blank`, `red`, `green` and `blue` are all low.
- R3: Inside the window, with x = h-hstart and y = v-vstart, the dot belongs to text row y/15, column x/11, glyph line y%15 and dot x%11. The cell code is read from screen entry row*20+col. Glyph word bit 10 is the leftmost dot and bit 0 is the rightmost.
- R4: A lit dot takes its row's 3-bit color, with bit 2 driving red, bit 1 green and bit 0 blue.
- R5: When the bar enable bit is set, lit dots in the bar row whose column is greater than or equal to the split column take the bar color. All other dots keep their row color. When the bar enable bit is clear, the bar settings have no effect.
- R6: A cell holding code 0 shows no lit dots and keeps `blank` low, whatever the glyph store holds for code 0.
- R7: `blank` is high exactly on lit dots. A lit dot in a row whose color is 0 has `blank` high and all color outputs low.
- R8: The output for dot h is presented during enabled cycle h+3. The outputs hold their value while `dot_en` is low.
- R9: While `vsync` is sampled high, the line count resets to 0. Each leading edge of `hsync` adds one to the line count.
- R10: Host address map, taken when `wr_valid` and `wr_ready` are both high:
  - bit 11 set: glyph word, with address bits 10:4 = code, bits 3:0 = line (0..14), and data bits 10:0 = pattern.
  - bits 11:8 = 0 and bits 7:0 < 160: screen cell row*20+col, with data bits 6:0 = code.
  - bits 11:8 = 1: control register selected by bits 3:0:
    - 0..7: row color, data bits 2:0.
    - 8: bar enable in data bit 3, bar row in data bits 2:0.
    - 9: split column, data bits 4:0.
    - 10: bar color, data bits 2:0.
    - 11: hstart.
    - 12: vstart.
  - `wr_ready` is high from the first clock edge after reset.
- R11: During reset, `dot_en` is high and all four video outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock source |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Host write accepted |
| wr_addr | input | 12 | Host write address |
| wr_data | input | 16 | Host write data |
| dot_en | output | 1 | Gated dot-clock enable |
| red | output | 1 | Red dot |
| green | output | 1 | Green dot |
| blue | output | 1 | Blue dot |
| blank | output | 1 | Overlay replaces video |

## Verification
The hardest state to reach from the ports is a lit dot in a late text row, such as the last glyph line of row 7. That needs over a hundred horizontal sync leading edges counted after vertical sync. The stimulus gets there by pulsing vertical sync and then sending a burst of one-cycle horizontal sync pulses with three-cycle gaps, each a very short line. Only the final full-length line is compared dot by dot against a model built from the screen codes, glyph patterns and row colors the bench itself wrote. The same lines also cover window offsets, the bar split at both extreme columns and code-0 cells with a fully lit glyph behind them.

// File: rtl/osd_pkg.sv
package osd_pkg;
  parameter int OSD_ROWS   = 8;
  parameter int OSD_COLS   = 20;
  parameter int OSD_CELL_W = 11;
  parameter int OSD_CELL_H = 15;
  parameter int OSD_CODES  = 128;
  parameter int HC_W       = 10;
  parameter int VC_W       = 9;
  parameter int HOST_DW    = 16;

  localparam int CODE_W  = $clog2(OSD_CODES);
  localparam int LINE_W  = $clog2(OSD_CELL_H);
  localparam int SUB_W   = $clog2(OSD_CELL_W);
  localparam int ROW_W   = $clog2(OSD_ROWS);
  localparam int COL_W   = $clog2(OSD_COLS);
  localparam int GLY_AW  = CODE_W + LINE_W;
  localparam int HOST_AW = GLY_AW + 1;
  localparam int SCR_N   = OSD_ROWS * OSD_COLS;
  localparam int SCR_AW  = $clog2(SCR_N);
  localparam int WIN_W   = OSD_COLS * OSD_CELL_W;
  localparam int WIN_H   = OSD_ROWS * OSD_CELL_H;

  localparam logic [3:0] SEL_BAR    = 4'd8;
  localparam logic [3:0] SEL_SPLIT  = 4'd9;
  localparam logic [3:0] SEL_BARCOL = 4'd10;
  localparam logic [3:0] SEL_HSTART = 4'd11;
  localparam logic [3:0] SEL_VSTART = 4'd12;

  typedef logic [2:0] rgb_t;
endpackage

// File: rtl/osd_sync_gate.sv
module osd_sync_gate
  import osd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hsync,
  input  logic            vsync,
  output logic            dot_en,
  output logic [HC_W-1:0] hcnt,
  output logic [VC_W-1:0] vcnt
);
  logic hs1, hs2, vs1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs1  <= 1'b0;
      hs2  <= 1'b0;
      vs1  <= 1'b0;
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hs1 <= hsync;
      hs2 <= hs1;
      vs1 <= vsync;
      if (hs2) hcnt <= '0;
      else if (hcnt != '1) hcnt <= hcnt + 1'b1;
      if (vs1) vcnt <= '0;
      else if (hs1 && !hs2 && vcnt != '1) vcnt <= vcnt + 1'b1;
    end
  end

  assign dot_en = !hs2;

  AST_DOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs1 && !hs2) |=> !dot_en); // R1
  AST_DOT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs1 && hs2) |=> dot_en); // R1
  AST_HCNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dot_en) |-> hcnt == '0); // R2
endmodule

// File: rtl/osd_regs.sv
module osd_regs
  import osd_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [HOST_AW-1:0]      wr_addr,
  input  logic [HOST_DW-1:0]      wr_data,
  input  logic [SCR_AW-1:0]       scr_addr,
  output logic [CODE_W-1:0]       scr_code,
  input  logic [GLY_AW-1:0]       gly_addr,
  output logic [OSD_CELL_W-1:0]   gly_word,
  output logic [OSD_ROWS*3-1:0]   row_colors,
  output logic                    bar_en,
  output logic [ROW_W-1:0]        bar_row,
  output logic [COL_W-1:0]        bar_split,
  output rgb_t                    bar_color,
  output logic [HC_W-1:0]         hstart,
  output logic [VC_W-1:0]         vstart
);
  logic [CODE_W-1:0]     scr_mem [SCR_N];
  logic [OSD_CELL_W-1:0] gly_mem [1<<GLY_AW];
  logic                  take, hit_gly, hit_scr, hit_ctl;
  logic [3:0]            sel;

  assign take    = wr_valid && wr_ready;
  assign hit_gly = wr_addr[HOST_AW-1];
  assign hit_scr = (wr_addr[HOST_AW-1:SCR_AW] == '0) &&
                   (int'(wr_addr[SCR_AW-1:0]) < SCR_N);
  assign hit_ctl = wr_addr[HOST_AW-1:SCR_AW] == (HOST_AW-SCR_AW)'(1);
  assign sel     = wr_addr[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ready <= 1'b0;
    else        wr_ready <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (take && hit_gly) gly_mem[wr_addr[GLY_AW-1:0]] <= wr_data[OSD_CELL_W-1:0];
    if (take && hit_scr) scr_mem[wr_addr[SCR_AW-1:0]] <= wr_data[CODE_W-1:0];
  end

  generate
    for (genvar r = 0; r < OSD_ROWS; r++) begin : g_rowcol
      rgb_t col_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) col_q <= '0;
        else if (take && hit_ctl && sel == 4'(r)) col_q <= wr_data[2:0];
      end
      assign row_colors[r*3 +: 3] = col_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bar_en    <= 1'b0;
      bar_row   <= '0;
      bar_split <= '0;
      bar_color <= '0;
      hstart    <= '0;
      vstart    <= '0;
    end else if (take && hit_ctl) begin
      case (sel)
        SEL_BAR:    begin bar_en <= wr_data[3]; bar_row <= wr_data[ROW_W-1:0]; end
        SEL_SPLIT:  bar_split <= wr_data[COL_W-1:0];
        SEL_BARCOL: bar_color <= wr_data[2:0];
        SEL_HSTART: hstart    <= wr_data[HC_W-1:0];
        SEL_VSTART: vstart    <= wr_data[VC_W-1:0];
        default: ;
      endcase
    end
  end

  assign scr_code = scr_mem[scr_addr];
  assign gly_word = gly_mem[gly_addr];

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable({bar_en, bar_row, bar_split, bar_color, hstart, vstart})); // R10
endmodule

// File: rtl/osd_pixel.sv
module osd_pixel
  import osd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [HC_W-1:0]       hcnt,
  input  logic [VC_W-1:0]       vcnt,
  input  logic [HC_W-1:0]       hstart,
  input  logic [VC_W-1:0]       vstart,
  input  logic [OSD_ROWS*3-1:0] row_colors,
  input  logic                  bar_en,
  input  logic [ROW_W-1:0]      bar_row,
  input  logic [COL_W-1:0]      bar_split,
  input  rgb_t                  bar_color,
  output logic [SCR_AW-1:0]     scr_addr,
  input  logic [CODE_W-1:0]     scr_code,
  output logic [GLY_AW-1:0]     gly_addr,
  input  logic [OSD_CELL_W-1:0] gly_word,
  output logic                  red,
  output logic                  green,
  output logic                  blue,
  output logic                  blank
);
  logic [HC_W-1:0]       xo;
  logic [VC_W-1:0]       yo;
  logic                  in_win;
  logic [ROW_W-1:0]      row;
  logic [COL_W-1:0]      col;
  logic [LINE_W-1:0]     line;
  logic [SUB_W-1:0]      sub;
  rgb_t                  pick;

  logic                  s1_ok, s2_ok;
  logic [CODE_W-1:0]     s1_code;
  logic [LINE_W-1:0]     s1_line;
  logic [SUB_W-1:0]      s1_sub, s2_sub;
  rgb_t                  s1_color, s2_color;
  logic [OSD_CELL_W-1:0] s2_word;
  logic                  lit;

  assign xo     = hcnt - hstart;
  assign yo     = vcnt - vstart;
  assign in_win = (hcnt >= hstart) && (int'(xo) < WIN_W) &&
                  (vcnt >= vstart) && (int'(yo) < WIN_H);
  assign col    = COL_W'(int'(xo) / OSD_CELL_W);
  assign sub    = SUB_W'(int'(xo) % OSD_CELL_W);
  assign row    = ROW_W'(int'(yo) / OSD_CELL_H);
  assign line   = LINE_W'(int'(yo) % OSD_CELL_H);
  assign scr_addr = SCR_AW'(int'(row) * OSD_COLS + int'(col));

  always_comb begin
    if (bar_en && row == bar_row && col >= bar_split) pick = bar_color;
    else pick = row_colors[int'(row)*3 +: 3];
  end

  assign gly_addr = {s1_code, s1_line};
  assign lit      = s2_ok && s2_word[SUB_W'(OSD_CELL_W-1) - s2_sub];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_ok <= 1'b0; s1_code <= '0; s1_line <= '0; s1_sub <= '0; s1_color <= '0;
      s2_ok <= 1'b0; s2_word <= '0; s2_sub <= '0; s2_color <= '0;
      red <= 1'b0; green <= 1'b0; blue <= 1'b0; blank <= 1'b0;
    end else if (en) begin
      s1_ok    <= in_win;
      s1_code  <= scr_code;
      s1_line  <= line;
      s1_sub   <= sub;
      s1_color <= pick;
      s2_ok    <= s1_ok && (s1_code != '0);
      s2_word  <= gly_word;
      s2_sub   <= s1_sub;
      s2_color <= s1_color;
      blank    <= lit;
      red      <= lit && s2_color[2];
      green    <= lit && s2_color[1];
      blue     <= lit && s2_color[0];
    end
  end

  AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable({red, green, blue, blank})); // R8
  AST_OUT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !s2_ok) |=> !blank); // R2
  AST_COLOR_NEEDS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !s1_ok) |=> !s2_ok); // R2
endmodule

// File: rtl/row_osd.sv
module row_osd
  import osd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hsync,
  input  logic               vsync,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [HOST_AW-1:0] wr_addr,
  input  logic [HOST_DW-1:0] wr_data,
  output logic               dot_en,
  output logic               red,
  output logic               green,
  output logic               blue,
  output logic               blank
);
  logic [HC_W-1:0]       hcnt, hstart;
  logic [VC_W-1:0]       vcnt, vstart;
  logic [SCR_AW-1:0]     scr_addr;
  logic [CODE_W-1:0]     scr_code;
  logic [GLY_AW-1:0]     gly_addr;
  logic [OSD_CELL_W-1:0] gly_word;
  logic [OSD_ROWS*3-1:0] row_colors;
  logic                  bar_en;
  logic [ROW_W-1:0]      bar_row;
  logic [COL_W-1:0]      bar_split;
  rgb_t                  bar_color;

  osd_sync_gate u_sync (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .dot_en(dot_en), .hcnt(hcnt), .vcnt(vcnt)
  );

  osd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .scr_addr(scr_addr), .scr_code(scr_code),
    .gly_addr(gly_addr), .gly_word(gly_word),
    .row_colors(row_colors), .bar_en(bar_en), .bar_row(bar_row),
    .bar_split(bar_split), .bar_color(bar_color),
    .hstart(hstart), .vstart(vstart)
  );

  osd_pixel u_pix (
    .clk(clk), .rst_n(rst_n), .en(dot_en), .hcnt(hcnt), .vcnt(vcnt),
    .hstart(hstart), .vstart(vstart), .row_colors(row_colors),
    .bar_en(bar_en), .bar_row(bar_row), .bar_split(bar_split), .bar_color(bar_color),
    .scr_addr(scr_addr), .scr_code(scr_code),
    .gly_addr(gly_addr), .gly_word(gly_word),
    .red(red), .green(green), .blue(blue), .blank(blank)
  );
endmodule

// File: tb/row_osd_bench.sv
module row_osd_bench;
  logic        clk = 1'b0;
  logic        rst_n, hsync, vsync, wr_valid;
  logic [11:0] wr_addr;
  logic [15:0] wr_data;
  logic        wr_ready, dot_en, red, green, blue, blank;

  always #2 clk = ~clk;

  row_osd u_row_osd (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .dot_en(dot_en), .red(red), .green(green), .blue(blue), .blank(blank)
  );

  int total = 0;
  int bad   = 0;
  int scr_m [160];
  int rc    [8];
  int c_hs, c_vs, c_ben, c_brow, c_split, c_bc;

  localparam int NV = 8;
  localparam int T_HS    [NV] = '{0, 5, 12, 1, 20, 3, 7, 0};
  localparam int T_VS    [NV] = '{0, 3, 2, 0, 10, 1, 4, 0};
  localparam int T_LINE  [NV] = '{1, 17, 24, 119, 5, 121, 64, 45};
  localparam int T_BEN   [NV] = '{0, 1, 1, 1, 0, 0, 1, 0};
  localparam int T_BROW  [NV] = '{0, 0, 3, 7, 0, 0, 4, 3};
  localparam int T_SPLIT [NV] = '{0, 4, 0, 19, 0, 0, 0, 10};
  localparam int T_BC    [NV] = '{0, 5, 6, 2, 0, 0, 6, 1};

  function automatic int gpat(int code, int line);
    if (code == 0) return 2047;
    return ((code * 29 + line * 13 + 3) * 41) % 2048;
  endfunction

  function automatic int exp_pix(int h, int v);
    int x, y, r, c, code, w, colr;
    if (h < c_hs || h >= c_hs + 220 || v < c_vs || v >= c_vs + 120) return 0;
    x = h - c_hs; y = v - c_vs; r = y / 15; c = x / 11;
    code = scr_m[r * 20 + c];
    if (code == 0) return 0;
    w = gpat(code, y % 15);
    if (((w >> (10 - (x % 11))) & 1) == 0) return 0;
    colr = (c_ben != 0 && r == c_brow && c >= c_split) ? c_bc : rc[r];
    return 8 + colr;
  endfunction

  function automatic string tag_of(int h, int v);
    int x, y, r, c;
    if (h < c_hs || h >= c_hs + 220 || v < c_vs || v >= c_vs + 120) return "R2";
    x = h - c_hs; y = v - c_vs; r = y / 15; c = x / 11;
    if (scr_m[r * 20 + c] == 0) return "R6";
    if (c_ben != 0 && r == c_brow) return "R5";
    if (rc[r] == 0) return "R7";
    return "R3 R4 R8 R9";
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 12'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hsync = 1'b0; vsync = 1'b0;
    wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    check("R11", {28'd0, dot_en, red, green, blue}, 8);
    check("R11", int'(blank), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", int'(wr_ready), 1);

    // R10 load glyphs, screen and row colors
    for (int code = 0; code < 6; code++)
      for (int ln = 0; ln < 15; ln++)
        wr(2048 + code * 16 + ln, gpat(code, ln));
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 20; c++) begin
        scr_m[r * 20 + c] = (r * 7 + c * 3) % 6;
        wr(r * 20 + c, scr_m[r * 20 + c]);
      end
    for (int r = 0; r < 8; r++) begin
      rc[r] = (r + 3) % 8;
      wr(256 + r, rc[r]);
    end

    // R1 dot gating around horizontal sync
    @(negedge clk); hsync = 1'b1;
    @(negedge clk); check("R1", int'(dot_en), 1);
    @(negedge clk); check("R1", int'(dot_en), 0);
    repeat (3) @(negedge clk);
    check("R1", int'(dot_en), 0);
    hsync = 1'b0;
    @(negedge clk); check("R1", int'(dot_en), 0);
    @(negedge clk); check("R1", int'(dot_en), 1);

    for (int i = 0; i < NV; i++) begin
      c_hs = T_HS[i]; c_vs = T_VS[i]; c_ben = T_BEN[i];
      c_brow = T_BROW[i]; c_split = T_SPLIT[i]; c_bc = T_BC[i];
      wr(256 + 11, c_hs);
      wr(256 + 12, c_vs);
      wr(256 + 8, c_ben * 8 + c_brow);
      wr(256 + 9, c_split);
      wr(256 + 10, c_bc);
      // R9 vsync clears the line count, each hsync adds one
      @(negedge clk); vsync = 1'b1;
      repeat (3) @(negedge clk);
      vsync = 1'b0;
      repeat (3) @(negedge clk);
      for (int p = 0; p < T_LINE[i] - 1; p++) begin
        hsync = 1'b1; @(negedge clk);
        hsync = 1'b0; repeat (3) @(negedge clk);
      end
      hsync = 1'b1; repeat (3) @(negedge clk);
      hsync = 1'b0;
      do @(negedge clk); while (!dot_en);
      for (int k = 0; k < c_hs + 232; k++) begin
        if (k >= 3)
          check(tag_of(k - 3, T_LINE[i]), {28'd0, blank, red, green, blue},
                exp_pix(k - 3, T_LINE[i]));
        @(negedge clk);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule